// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block observes the decoded command stream that a DDR SDRAM controller sends to a four-bank memory. For each bank it keeps one of three states: idle, open (a row is active), or precharging. It also keeps the burst length and CAS latency held in the base mode register. Every command is checked against the bank rules. A command that breaks a rule is rejected: it changes no tracked state, and it raises a one-cycle error pulse with a code and the bank number of the command.

The tracker follows burst occupancy itself. A burst takes half the burst length in clock cycles. This lets it close a bank at the end of an auto-precharge burst and catch commands that would cut such a burst short. Programmable counters enforce the precharge-to-activate spacing and the spacing after a mode register load. The data path, DLL, analog timing and power-down modes are outside this block.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank reads idle, the burst length reads 2, the CAS latency reads 4 half-clocks, and no error is flagged. The per-bank state code is 0 for idle, 1 for open and 2 for precharging, with bank b at bits [2b+1:2b] of bank_state_o.
- R2: ACTIVE (cmd 1) to an idle bank opens it on the next cycle. ACTIVE to a bank that is open or precharging raises error code 2 and leaves the state unchanged.
- R3: READ (cmd 2) or WRITE (cmd 3) to a bank that is not open raises error code 1.
- R4: PRECHARGE (cmd 4) with address bit 10 low moves only the addressed open bank to precharging. With bit 10 high it moves every open bank to precharging and the bank address is ignored. A precharge that reaches an idle or precharging bank leaves that bank as it is and raises no error.
- R5: A bank precharged by the command sampled at cycle t reads precharging until cycle t+T_RP, when it becomes idle. ACTIVE to that bank before cycle t+T_RP raises code 2.
- R6: An accepted READ or WRITE sets burst_busy_o for burst length/2 cycles. With address bit 10 high the bank stays open for those cycles, then precharges for T_RP cycles and becomes idle. With bit 10 low the bank stays open.
- R7: LOAD MODE (cmd 5) with bank address 0 takes the burst length from address bits [2:0] (1→2, 2→4, 3→8) and the CAS latency from bits [6:4] (2→4, 6→5, 3→6 half-clocks). Any other burst length code raises code 4 and any other latency code raises code 5. In both cases the registers keep their values. A load with any other bank address (1 selects the extended register) leaves both values unchanged.
- R8: LOAD MODE or AUTO REFRESH (cmd 7) while any bank is not idle or a burst is running raises code 3.
- R9: Any command other than NOP (cmd 0) in the T_MRD−1 cycles after an accepted LOAD MODE raises code 6.
- R10: While an auto-precharge burst runs, READ, WRITE, BURST TERMINATE (cmd 6), and a PRECHARGE that covers that burst's bank raise code 7. ACTIVE, and PRECHARGE to other banks, are still accepted.
- R11: err_o pulses on the cycle after the offending command. err_code_o is then nonzero and err_bank_o equals that command's bank address; both read 0 when no error is flagged. A rejected command changes no state, NOP never errors, and an accepted BURST TERMINATE clears burst_busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 LOAD MODE, 6 BURST TERMINATE, 7 AUTO REFRESH |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address bus; bit 10 selects all-bank or auto precharge |
| bank_state_o | output | 2*NUM_BANKS | Per-bank state codes |
| burst_len_o | output | 4 | Programmed burst length |
| cas_half_o | output | 3 | Programmed CAS latency in half-clocks |
| burst_busy_o | output | 1 | A burst is occupying the bus |
| err_o | output | 1 | One-cycle protocol error pulse |
| err_code_o | output | 3 | Error code, 0 when no error |
| err_bank_o | output | BA_W | Bank address of the offending command |

## Verification
Directed sequences first cover single-bank and all-bank precharge, so a wrong A10 decode shows up as a bank closed or left open in error. They then test activation on the exact cycles before and at the end of the precharge window, which exposes an off-by-one in the timer. Further directed cases cover mode loads with legal codes, reserved codes and the extended bank address, and an auto-precharge burst that is overlapped by commands to the same bank and to other banks. The random phase then sends weighted command mixes, with mostly legal mode codes, so that long runs of concurrent open banks, truncations and mode-delay hits occur. Each cycle is compared with a reference model in the bench.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_LMR = 3'd5,
    CMD_BST = 3'd6,
    CMD_REF = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_PRECHG = 2'd2
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_CLOSED = 3'd1,
    ERR_REOPEN = 3'd2,
    ERR_BUSY   = 3'd3,
    ERR_BL     = 3'd4,
    ERR_CL     = 3'd5,
    ERR_MRD    = 3'd6,
    ERR_APINT  = 3'd7
  } err_e;

  localparam int AP_BIT = 10;

  // burst length from code, 0 = reserved
  function automatic logic [3:0] bl_decode(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // CAS latency in half clocks, 0 = reserved
  function automatic logic [2:0] cl_decode(input logic [2:0] code);
    case (code)
      3'd2:    return 3'd4;
      3'd6:    return 3'd5;
      3'd3:    return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank
  import ddr_trk_pkg::*;
#(
  parameter int T_RP = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       pre_i,
  input  logic       ap_close_i,
  output logic [1:0] state_o
);

  localparam int RP_W = (T_RP > 1) ? $clog2(T_RP + 1) : 1;

  bank_st_e        st_q;
  logic [RP_W-1:0] rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= BK_IDLE;
      rp_q <= '0;
    end else if (act_i) begin
      st_q <= BK_OPEN;
    end else if ((pre_i || ap_close_i) && st_q == BK_OPEN) begin
      if (T_RP > 1) begin
        st_q <= BK_PRECHG;
        rp_q <= RP_W'(T_RP - 1);
      end else begin
        st_q <= BK_IDLE;
      end
    end else if (st_q == BK_PRECHG) begin
      if (rp_q <= RP_W'(1)) begin
        st_q <= BK_IDLE;
        rp_q <= '0;
      end else begin
        rp_q <= rp_q - RP_W'(1);
      end
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/ddr_trk_burst.sv
module ddr_trk_burst #(
  parameter  int NB     = 4,
  parameter  int MAX_BL = 8,
  localparam int BA_W   = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rw_i,
  input  logic            rw_ap_i,
  input  logic [BA_W-1:0] rw_bank_i,
  input  logic            bst_i,
  input  logic [3:0]      bl_i,
  output logic            busy_o,
  output logic            ap_run_o,
  output logic [BA_W-1:0] ap_bank_o,
  output logic [NB-1:0]   ap_close_o
);

  localparam int CNT_W = $clog2(MAX_BL / 2 + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;
  logic [BA_W-1:0]  bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (bst_i) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (rw_i) begin
      cnt_q  <= CNT_W'(bl_i >> 1);
      ap_q   <= rw_ap_i;
      bank_q <= rw_bank_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) ap_q <= 1'b0;
    end
  end

  assign busy_o    = cnt_q != '0;
  assign ap_run_o  = ap_q && busy_o;
  assign ap_bank_o = bank_q;

  // last beat of an auto-precharge burst closes its bank
  for (genvar b = 0; b < NB; b++) begin : g_close
    assign ap_close_o[b] = ap_q && cnt_q == CNT_W'(1) && bank_q == BA_W'(b);
  end

endmodule

// File: rtl/ddr_trk_mode.sv
module ddr_trk_mode
  import ddr_trk_pkg::*;
#(
  parameter  int T_MRD = 2,
  parameter  int NB    = 4,
  localparam int BA_W  = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lmr_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic [6:0]      field_i,
  output logic [3:0]      bl_o,
  output logic [2:0]      cas_o,
  output logic            bl_ok_o,
  output logic            cl_ok_o,
  output logic            mrd_busy_o
);

  localparam int MRD_W = (T_MRD > 1) ? $clog2(T_MRD + 1) : 1;

  logic [3:0]       bl_q;
  logic [2:0]       cas_q;
  logic [MRD_W-1:0] mrd_q;
  logic [3:0]       bl_new;
  logic [2:0]       cas_new;

  assign bl_new  = bl_decode(field_i[2:0]);
  assign cas_new = cl_decode(field_i[6:4]);
  assign bl_ok_o = bl_new != '0;
  assign cl_ok_o = cas_new != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q  <= 4'd2;
      cas_q <= 3'd4;
      mrd_q <= '0;
    end else if (lmr_i) begin
      mrd_q <= MRD_W'(T_MRD - 1);
      if (ba_i == '0) begin
        bl_q  <= bl_new;
        cas_q <= cas_new;
      end
    end else if (mrd_q != '0) begin
      mrd_q <= mrd_q - MRD_W'(1);
    end
  end

  assign bl_o       = bl_q;
  assign cas_o      = cas_q;
  assign mrd_busy_o = mrd_q != '0;

endmodule

// File: rtl/ddr_trk_rules.sv
module ddr_trk_rules
  import ddr_trk_pkg::*;
#(
  parameter  int NB   = 4,
  localparam int BA_W = $clog2(NB)
) (
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [NB-1:0][1:0]   st_i,
  input  logic                 burst_busy_i,
  input  logic                 ap_run_i,
  input  logic [BA_W-1:0]      ap_bank_i,
  input  logic                 mrd_busy_i,
  input  logic                 bl_ok_i,
  input  logic                 cl_ok_i,
  output logic                 err_o,
  output err_e                 code_o,
  output logic                 act_go_o,
  output logic                 rw_go_o,
  output logic                 lmr_go_o,
  output logic                 bst_go_o,
  output logic [NB-1:0]        pre_mask_o
);

  logic     any_busy;
  bank_st_e sel_st;
  logic     ok;

  always_comb begin
    any_busy = burst_busy_i;
    for (int b = 0; b < NB; b++) begin
      if (st_i[b] != BK_IDLE) any_busy = 1'b1;
    end
  end

  assign sel_st = bank_st_e'(st_i[ba_i]);

  always_comb begin
    code_o = ERR_NONE;
    if (cmd_i != CMD_NOP && mrd_busy_i) begin
      code_o = ERR_MRD;
    end else begin
      case (cmd_i)
        CMD_ACT: if (sel_st != BK_IDLE) code_o = ERR_REOPEN;
        CMD_RD, CMD_WR: begin
          if (ap_run_i)                code_o = ERR_APINT;
          else if (sel_st != BK_OPEN)  code_o = ERR_CLOSED;
        end
        CMD_PRE: if (ap_run_i && (a10_i || ba_i == ap_bank_i)) code_o = ERR_APINT;
        CMD_LMR: begin
          if (any_busy)                       code_o = ERR_BUSY;
          else if (ba_i == '0 && !bl_ok_i)    code_o = ERR_BL;
          else if (ba_i == '0 && !cl_ok_i)    code_o = ERR_CL;
        end
        CMD_BST: if (ap_run_i) code_o = ERR_APINT;
        CMD_REF: if (any_busy) code_o = ERR_BUSY;
        default: code_o = ERR_NONE;
      endcase
    end
  end

  assign err_o    = code_o != ERR_NONE;
  assign ok       = !err_o;
  assign act_go_o = ok && cmd_i == CMD_ACT;
  assign rw_go_o  = ok && (cmd_i == CMD_RD || cmd_i == CMD_WR);
  assign lmr_go_o = ok && cmd_i == CMD_LMR;
  assign bst_go_o = ok && cmd_i == CMD_BST;

  for (genvar b = 0; b < NB; b++) begin : g_pre
    assign pre_mask_o[b] = ok && cmd_i == CMD_PRE && (a10_i || ba_i == BA_W'(b));
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ADDR_W    = 12,
  parameter  int T_RP      = 3,
  parameter  int T_MRD     = 2,
  parameter  int MAX_BL    = 8,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             cmd_i,
  input  logic [BA_W-1:0]        ba_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic [3:0]             burst_len_o,
  output logic [2:0]             cas_half_o,
  output logic                   burst_busy_o,
  output logic                   err_o,
  output logic [2:0]             err_code_o,
  output logic [BA_W-1:0]        err_bank_o
);

  cmd_e                       cmd;
  logic                       a10;
  logic [NUM_BANKS-1:0][1:0]  st;
  logic [NUM_BANKS-1:0]       pre_mask;
  logic [NUM_BANKS-1:0]       ap_close;
  logic                       busy, ap_run, mrd_busy, bl_ok, cl_ok;
  logic [BA_W-1:0]            ap_bank;
  logic                       err, act_go, rw_go, lmr_go, bst_go;
  err_e                       code;
  logic [3:0]                 bl;
  logic                       unused_addr;

  assign cmd         = cmd_e'(cmd_i);
  assign a10         = addr_i[AP_BIT];
  assign unused_addr = ^addr_i;

  ddr_trk_rules #(.NB(NUM_BANKS)) u_rules (
    .cmd_i        (cmd),
    .ba_i         (ba_i),
    .a10_i        (a10),
    .st_i         (st),
    .burst_busy_i (busy),
    .ap_run_i     (ap_run),
    .ap_bank_i    (ap_bank),
    .mrd_busy_i   (mrd_busy),
    .bl_ok_i      (bl_ok),
    .cl_ok_i      (cl_ok),
    .err_o        (err),
    .code_o       (code),
    .act_go_o     (act_go),
    .rw_go_o      (rw_go),
    .lmr_go_o     (lmr_go),
    .bst_go_o     (bst_go),
    .pre_mask_o   (pre_mask)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_trk_bank #(.T_RP(T_RP)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_go && ba_i == BA_W'(b)),
      .pre_i      (pre_mask[b]),
      .ap_close_i (ap_close[b]),
      .state_o    (st[b])
    );
  end

  ddr_trk_burst #(.NB(NUM_BANKS), .MAX_BL(MAX_BL)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rw_i       (rw_go),
    .rw_ap_i    (a10),
    .rw_bank_i  (ba_i),
    .bst_i      (bst_go),
    .bl_i       (bl),
    .busy_o     (busy),
    .ap_run_o   (ap_run),
    .ap_bank_o  (ap_bank),
    .ap_close_o (ap_close)
  );

  ddr_trk_mode #(.T_MRD(T_MRD), .NB(NUM_BANKS)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lmr_i      (lmr_go),
    .ba_i       (ba_i),
    .field_i    (addr_i[6:0]),
    .bl_o       (bl),
    .cas_o      (cas_half_o),
    .bl_ok_o    (bl_ok),
    .cl_ok_o    (cl_ok),
    .mrd_busy_o (mrd_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= '0;
      err_bank_o <= '0;
    end else begin
      err_o      <= err;
      err_code_o <= code;
      err_bank_o <= err ? ba_i : '0;
    end
  end

  assign bank_state_o = st;
  assign burst_len_o  = bl;
  assign burst_busy_o = busy;

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
  parameter  int NUM_BANKS = 4,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             cmd_i,
  input logic [BA_W-1:0]        ba_i,
  input logic                   a10_i,
  input logic [2*NUM_BANKS-1:0] bank_state_o,
  input logic [3:0]             burst_len_o,
  input logic [2:0]             cas_half_o,
  input logic                   burst_busy_o,
  input logic                   err_o,
  input logic [2:0]             err_code_o,
  input logic [BA_W-1:0]        err_bank_o
);

  logic [2:0]      cmd_q;
  logic [BA_W-1:0] ba_q;
  logic            a10_q;
  logic [1:0]      st_q;
  logic [1:0]      cur_st;
  logic            any_open;
  logic            bad_enc;

  assign cur_st = bank_state_o[ba_i*2 +: 2];

  always_comb begin
    any_open = 1'b0;
    bad_enc  = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_state_o[b*2 +: 2] == 2'd1) any_open = 1'b1;
      if (bank_state_o[b*2 +: 2] == 2'd3) bad_enc  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      ba_q  <= '0;
      a10_q <= 1'b0;
      st_q  <= '0;
    end else begin
      cmd_q <= cmd_i;
      ba_q  <= ba_i;
      a10_q <= a10_i;
      st_q  <= cur_st;
    end
  end

  AST_STATE_ENC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_enc); // R1
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == 3'd1 && !err_o |-> bank_state_o[ba_q*2 +: 2] == 2'd1); // R2
  AST_REOPEN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == 3'd1 && st_q != 2'd0 |-> err_o); // R2
  AST_CLOSED_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == 3'd2 || cmd_q == 3'd3) && st_q != 2'd1 |-> err_o); // R3
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == 3'd4 && a10_q && !err_o |-> !any_open); // R4
  AST_BL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_len_o == 4'd2 || burst_len_o == 4'd4 || burst_len_o == 4'd8); // R7
  AST_CL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_half_o == 3'd4 || cas_half_o == 3'd5 || cas_half_o == 3'd6); // R7
  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == 3'd0 |-> !err_o); // R11
  AST_ERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 3'd0 && err_bank_o == ba_q); // R11
  AST_NO_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> err_code_o == 3'd0 && err_bank_o == '0); // R11
  AST_BST_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == 3'd6 && !err_o |-> !burst_busy_o); // R11

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_i        (cmd_i),
  .ba_i         (ba_i),
  .a10_i        (addr_i[10]),
  .bank_state_o (bank_state_o),
  .burst_len_o  (burst_len_o),
  .cas_half_o   (cas_half_o),
  .burst_busy_o (burst_busy_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o),
  .err_bank_o   (err_bank_o)
);

// File: tb/ddr_bank_tracker_tb_top.sv
module ddr_bank_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int TRP        = 3;
  localparam int TMRD       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [11:0] addr = 12'd0;
  logic [7:0]  bank_state;
  logic [3:0]  burst_len;
  logic [2:0]  cas_half;
  logic        burst_busy, err;
  logic [2:0]  err_code;
  logic [1:0]  err_bank;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  int m_st[NB];
  int m_rp[NB];
  int m_bc, m_ap, m_apb, m_mrd, m_bl, m_cl;
  int e_code, e_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_bank_tracker #(.NUM_BANKS(NB), .ADDR_W(12), .T_RP(TRP), .T_MRD(TMRD), .MAX_BL(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .bank_state_o(bank_state), .burst_len_o(burst_len), .cas_half_o(cas_half),
    .burst_busy_o(burst_busy), .err_o(err), .err_code_o(err_code), .err_bank_o(err_bank)
  );

  function automatic int bl_of(input int c);
    return (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 0;
  endfunction

  function automatic int cl_of(input int c);
    return (c == 2) ? 4 : (c == 6) ? 5 : (c == 3) ? 6 : 0;
  endfunction

  function automatic int st_of(input int b);
    return int'(bank_state[b*2 +: 2]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_rp[b] = 0; end
    m_bc = 0; m_ap = 0; m_apb = 0; m_mrd = 0; m_bl = 2; m_cl = 4;
    e_code = 0; e_bank = 0;
  endtask

  task automatic model_step(input int c, input int b, input int a);
    int  a10, apr, busy_any, ok;
    bit  close[NB];
    a10 = (a >> 10) & 1;
    apr = (m_ap != 0 && m_bc != 0) ? 1 : 0;
    busy_any = (m_bc != 0) ? 1 : 0;
    for (int k = 0; k < NB; k++) if (m_st[k] != 0) busy_any = 1;
    e_code = 0;
    if (c != 0 && m_mrd != 0) e_code = 6;
    else case (c)
      1: if (m_st[b] != 0) e_code = 2;
      2, 3: if (apr != 0) e_code = 7; else if (m_st[b] != 1) e_code = 1;
      4: if (apr != 0 && (a10 != 0 || b == m_apb)) e_code = 7;
      5: if (busy_any != 0) e_code = 3;
         else if (b == 0 && bl_of(a & 7) == 0) e_code = 4;
         else if (b == 0 && cl_of((a >> 4) & 7) == 0) e_code = 5;
      6: if (apr != 0) e_code = 7;
      7: if (busy_any != 0) e_code = 3;
      default: ;
    endcase
    ok = (e_code == 0) ? 1 : 0;
    e_bank = ok ? 0 : b;
    for (int k = 0; k < NB; k++) close[k] = (m_ap != 0 && m_bc == 1 && m_apb == k);
    for (int k = 0; k < NB; k++) begin
      if (ok && c == 1 && b == k) m_st[k] = 1;
      else if (((ok && c == 4 && (a10 != 0 || b == k)) || close[k]) && m_st[k] == 1) begin
        if (TRP > 1) begin m_st[k] = 2; m_rp[k] = TRP - 1; end else m_st[k] = 0;
      end else if (m_st[k] == 2) begin
        if (m_rp[k] <= 1) begin m_st[k] = 0; m_rp[k] = 0; end else m_rp[k]--;
      end
    end
    if (ok && c == 6) begin m_bc = 0; m_ap = 0; end
    else if (ok && (c == 2 || c == 3)) begin m_bc = m_bl / 2; m_ap = a10; m_apb = b; end
    else if (m_bc != 0) begin if (m_bc == 1) m_ap = 0; m_bc--; end
    if (ok && c == 5) begin
      m_mrd = TMRD - 1;
      if (b == 0) begin m_bl = bl_of(a & 7); m_cl = cl_of((a >> 4) & 7); end
    end else if (m_mrd != 0) m_mrd--;
  endtask

  task automatic issue(input int c, input int b, input int a);
    @(negedge clk);
    cmd = c[2:0]; ba = b[1:0]; addr = a[11:0];
    @(posedge clk);
    model_step(c, b, a);
    #1;
  endtask

  function automatic int packed_out();
    return {bank_state, burst_len, cas_half, burst_busy, err, err_code, err_bank};
  endfunction

  function automatic int packed_exp();
    logic [7:0] s;
    for (int k = 0; k < NB; k++) s[k*2 +: 2] = m_st[k][1:0];
    return {s, m_bl[3:0], m_cl[2:0], (m_bc != 0), (e_code != 0), e_code[2:0], e_bank[1:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int c, b, a, r;
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 states", int'(bank_state), 0);
    chk("R1 burst len", int'(burst_len), 2);
    chk("R1 cas", int'(cas_half), 4);
    chk("R1 err", int'(err), 0);

    issue(1, 0, 0);
    chk("R2 act opens", st_of(0), 1);
    issue(1, 0, 0);
    chk("R2 reopen code", int'(err_code), 2);
    chk("R2 reopen state", st_of(0), 1);
    issue(2, 1, 0);
    chk("R3 closed read", int'(err_code), 1);
    chk("R11 err bank", int'(err_bank), 1);
    issue(5, 0, 'h33);
    chk("R8 lmr busy", int'(err_code), 3);
    issue(1, 2, 0);
    issue(3, 2, 0);
    chk("R6 write busy", int'(burst_busy), 1);
    issue(0, 0, 0);
    chk("R6 bl2 ends", int'(burst_busy), 0);
    chk("R6 stays open", st_of(2), 1);

    issue(4, 0, 0);
    chk("R4 single pre", st_of(0), 2);
    chk("R4 other open", st_of(2), 1);
    issue(1, 0, 0);
    chk("R5 early act", int'(err_code), 2);
    issue(0, 0, 0);
    chk("R5 idle at trp", st_of(0), 0);
    issue(1, 0, 0);
    chk("R5 act legal", st_of(0), 1);

    issue(4, 3, 'h400);
    chk("R4 all pre", int'(bank_state), 8'b00_10_00_10);
    chk("R4 no err", int'(err), 0);
    issue(0, 0, 0); issue(0, 0, 0); issue(0, 0, 0);

    issue(5, 0, 'h33);
    chk("R7 bl8", int'(burst_len), 8);
    chk("R7 cl3", int'(cas_half), 6);
    issue(1, 1, 0);
    chk("R9 mrd window", int'(err_code), 6);
    issue(1, 1, 0);
    chk("R9 after window", st_of(1), 1);
    issue(4, 1, 0);
    issue(0, 0, 0); issue(0, 0, 0); issue(0, 0, 0);
    issue(5, 0, 'h25);
    chk("R7 bad bl code", int'(err_code), 4);
    chk("R7 bl kept", int'(burst_len), 8);
    issue(5, 0, 'h72);
    chk("R7 bad cl code", int'(err_code), 5);
    chk("R7 cl kept", int'(cas_half), 6);
    issue(5, 1, 'h01);
    chk("R7 ext no err", int'(err), 0);
    chk("R7 ext keeps bl", int'(burst_len), 8);
    issue(0, 0, 0);
    issue(5, 0, 'h62);
    chk("R7 bl4", int'(burst_len), 4);
    chk("R7 cl2.5", int'(cas_half), 5);
    issue(0, 0, 0);

    issue(1, 3, 0);
    issue(2, 3, 'h400);
    chk("R6 ap busy", int'(burst_busy), 1);
    issue(1, 0, 0);
    chk("R10 act other bank", st_of(0), 1);
    chk("R10 act no err", int'(err), 0);
    issue(2, 0, 0);
    chk("R10 interrupt code", int'(err_code), 7);
    chk("R6 ap closes", st_of(3), 2);
    chk("R6 burst done", int'(burst_busy), 0);
    issue(0, 0, 0); issue(0, 0, 0);
    chk("R6 ap idle", st_of(3), 0);

    issue(2, 0, 0);
    issue(0, 0, 0);
    issue(0, 0, 0);
    chk("R6 no ap open", st_of(0), 1);
    chk("R6 no ap done", int'(burst_busy), 0);

    issue(3, 0, 'h400);
    issue(4, 2, 0);
    chk("R10 pre other ok", int'(err), 0);
    issue(4, 1, 'h400);
    chk("R10 pre all interrupt", int'(err_code), 7);
    chk("R11 rejected keeps", st_of(0), 2);
    issue(0, 0, 0); issue(0, 0, 0); issue(0, 0, 0);

    issue(1, 1, 0);
    issue(7, 0, 0);
    chk("R8 refresh busy", int'(err_code), 3);
    issue(2, 1, 0);
    issue(6, 1, 0);
    chk("R11 bst clears", int'(burst_busy), 0);
    chk("R11 bst no err", int'(err), 0);
    issue(4, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom % 16);
      c = (r < 4 || r == 15) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : (r == 9) ? 3 :
          (r < 12) ? 4 : (r == 12) ? 5 : (r == 13) ? 6 : 7;
      b = int'($urandom % 4);
      a = int'($urandom % 4096);
      if (c == 5) begin
        if ($urandom % 4 != 0) b = 0;
        r = int'($urandom % 4);
        a = (a & ~'h77) | ((r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 3 : (a & 7));
        r = int'($urandom % 4);
        a = a | (((r == 0) ? 2 : (r == 1) ? 6 : (r == 2) ? 3 : ((a >> 8) & 7)) << 4);
      end
      issue(c, b, a);
      chk("R11 random vs model", packed_out(), packed_exp());
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule